// File: doc/BRIEF.md
# Timer counter with match and capture

The block is a 32-bit up counter fed by a 32-bit prescaler. The counter advances on timer ticks. The prescaler turns count events into ticks, so the counter steps once for every limit+1 events. In timer mode every system clock cycle is an event. In counter mode an event is a selected edge of an external clock pin, after that pin has passed through a two-flop synchronizer.

Four compare channels watch the counter value. A compare hit happens on a tick taken while the counter equals the channel's value. On a hit the channel can raise an interrupt, send the counter and prescaler back to zero, or stop counting. Each channel also drives its own output pin: it can leave the pin unchanged, drive it low, drive it high or toggle it. Four snapshot channels copy the counter into their own register on a chosen edge of their input pin, and each can raise an interrupt.

Software uses a plain word-addressed register port. Each word address selects one register:
- 0: control
- 1: counter value
- 2: prescale limit
- 3: prescaler count
- 4: event status
- 5: compare actions
- 6: snapshot edges
- 7: output actions
- 8 to 11: compare values
- 12 to 15: snapshot values

Top module: `tmr_match_capture`

## Requirements
- R1: After a synchronous reset the following are all zero: the counter, the prescaler, every register, every match output and the interrupt output.
- R2: Control bit 0 is the run enable. In timer mode (control bit 1 = 0) with prescale limit P, the counter advances once every P+1 clock cycles while enabled. The counter holds its value while disabled.
- R3: With control bit 1 = 1, events are synchronized edges of ext_clk, and they still pass through the prescaler. Control bit 2 selects rising edges and control bit 3 selects falling edges.
- R4: Compare-action bit 3i+1 arms reset-on-hit for compare channel i. The tick taken while the counter equals compare value i returns both the counter and the prescaler to 0, so the counter wraps with a period of (M+1)(P+1) events.
- R5: Compare-action bit 3i+2 arms stop-on-hit for compare channel i. A hit clears control bit 0, and the counter keeps the compare value.
- R6: Compare-action bit 3i arms an interrupt for compare channel i, which sets status bit i on a hit. Writing 1 to a status bit clears it; writing 0 leaves it unchanged. irq is high, from the cycle the first bit is set, for as long as any status bit is set.
- R7: Output-action bits 2i+1:2i select what a hit on compare channel i does to match_out[i]: 0 keep, 1 low, 2 high, 3 toggle. The output changes at the hit tick.
- R8: Snapshot-edge bits 3i (rising), 3i+1 (falling) and 3i+2 (interrupt) configure snapshot channel i. On an enabled edge of cap_in[i], after two-flop synchronization, snapshot register i takes the counter value. If the interrupt bit is set, status bit 4+i is also set. Edges that are not enabled leave the register unchanged.
- R9: reg_rdata shows the register addressed at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| ext_clk | input | 1 | External count input (counter mode) |
| cap_in | input | 4 | Snapshot trigger inputs |
| match_out | output | 4 | Compare-driven output pins |
| irq | output | 1 | Interrupt, high while any status bit is set |

## Verification
The bench runs prescale and compare settings in which the counter has to wrap, stop or just count. The cases include a compare value of zero and a prescale of zero. An off-by-one in the wrap point or in prescaler clearing shows up as the wrong final count.

Stop-on-hit is checked by reading control bit 0 back without software clearing it. A design that only held the counter would leave that bit set.

The snapshot test gives the two channels opposite edge selections, and changes the counter between its edges. A channel that reacts to both edges, or that copies a stale value, fails this test. It also fails if it raises its interrupt without being enabled.

The status test writes 1 to the wrong bit first. A design that clears every status bit on any write would drop irq too early.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int A_CTRL   = 0;
  localparam int A_COUNT  = 1;
  localparam int A_PRESC  = 2;
  localparam int A_PCNT   = 3;
  localparam int A_STATUS = 4;
  localparam int A_MCTL   = 5;
  localparam int A_CCTL   = 6;
  localparam int A_OCTL   = 7;
  localparam int A_MATCH0 = 8;

  typedef enum logic [1:0] {
    OUT_KEEP   = 2'd0,
    OUT_LOW    = 2'd1,
    OUT_HIGH   = 2'd2,
    OUT_TOGGLE = 2'd3
  } out_act_e;
endpackage

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sh_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      last_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], din};
      last_q <= sh_q[STAGES-1];
    end
  end

  assign rise = sh_q[STAGES-1] & ~last_q;
  assign fall = ~sh_q[STAGES-1] & last_q;
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic [W-1:0] limit,
  input  logic         clear,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count,
  output logic         tick
);
  logic [W-1:0] pc_q;

  // ">=" recovers cleanly if the limit is lowered below the running count
  assign tick  = step & (pc_q >= limit);
  assign count = pc_q;

  always_ff @(posedge clk) begin
    if (rst)                pc_q <= '0;
    else if (load)          pc_q <= load_val;
    else if (clear || tick) pc_q <= '0;
    else if (step)          pc_q <= pc_q + 1'b1;
  end
endmodule

// File: rtl/tmr_match_pin.sv
module tmr_match_pin
  import tmr_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     hit,
  input  out_act_e act,
  output logic     pin
);
  always_ff @(posedge clk) begin
    if (rst) pin <= 1'b0;
    else if (hit) begin
      case (act)
        OUT_LOW:    pin <= 1'b0;
        OUT_HIGH:   pin <= 1'b1;
        OUT_TOGGLE: pin <= ~pin;
        default:    pin <= pin;
      endcase
    end
  end
endmodule

// File: rtl/tmr_match_capture.sv
module tmr_match_capture
  import tmr_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int NUM_MATCH   = 4,
  parameter int NUM_CAP     = 4,
  parameter int ADDR_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_wr,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [CNT_W-1:0]     reg_wdata,
  output logic [CNT_W-1:0]     reg_rdata,
  input  logic                 ext_clk,
  input  logic [NUM_CAP-1:0]   cap_in,
  output logic [NUM_MATCH-1:0] match_out,
  output logic                 irq
);
  localparam int ST_W     = NUM_MATCH + NUM_CAP;
  localparam int CAP_BASE = A_MATCH0 + NUM_MATCH;
  localparam int MC_W     = 3 * NUM_MATCH;
  localparam int CC_W     = 3 * NUM_CAP;
  localparam int OC_W     = 2 * NUM_MATCH;

  logic en_q, cmode_q, erise_q, efall_q;
  logic [CNT_W-1:0] tc_q, plim_q, pc, rd_mux;
  logic [CNT_W-1:0] mr_q [NUM_MATCH];
  logic [CNT_W-1:0] cr_q [NUM_CAP];
  logic [MC_W-1:0]  mctl_q;
  logic [CC_W-1:0]  cctl_q;
  logic [OC_W-1:0]  octl_q;
  logic [ST_W-1:0]  st_q, st_nxt, st_clr;

  logic wr_ctrl, wr_count, wr_presc, wr_pcnt, wr_status;
  logic ext_rise, ext_fall, cnt_event, tick, any_rst, any_stop;
  logic [NUM_MATCH-1:0] hit, m_irq, m_rst, m_stop;
  logic [NUM_CAP-1:0]   c_rise, c_fall, c_evt, c_irq;

  // register decode
  assign wr_ctrl   = reg_wr && (reg_addr == ADDR_W'(A_CTRL));
  assign wr_count  = reg_wr && (reg_addr == ADDR_W'(A_COUNT));
  assign wr_presc  = reg_wr && (reg_addr == ADDR_W'(A_PRESC));
  assign wr_pcnt   = reg_wr && (reg_addr == ADDR_W'(A_PCNT));
  assign wr_status = reg_wr && (reg_addr == ADDR_W'(A_STATUS));

  always_ff @(posedge clk) begin
    if (rst) begin
      cmode_q <= 1'b0;
      erise_q <= 1'b0;
      efall_q <= 1'b0;
      plim_q  <= '0;
      mctl_q  <= '0;
      cctl_q  <= '0;
      octl_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        cmode_q <= reg_wdata[1];
        erise_q <= reg_wdata[2];
        efall_q <= reg_wdata[3];
      end
      if (wr_presc) plim_q <= reg_wdata;
      if (reg_wr && reg_addr == ADDR_W'(A_MCTL)) mctl_q <= reg_wdata[MC_W-1:0];
      if (reg_wr && reg_addr == ADDR_W'(A_CCTL)) cctl_q <= reg_wdata[CC_W-1:0];
      if (reg_wr && reg_addr == ADDR_W'(A_OCTL)) octl_q <= reg_wdata[OC_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_MATCH; i++) begin
      if (rst) mr_q[i] <= '0;
      else if (reg_wr && reg_addr == ADDR_W'(A_MATCH0 + i)) mr_q[i] <= reg_wdata;
    end
  end

  // event source and prescaler
  tmr_sync_edge #(.STAGES(SYNC_STAGES)) u_ext_sync (
    .clk(clk), .rst(rst), .din(ext_clk), .rise(ext_rise), .fall(ext_fall)
  );

  assign cnt_event = en_q & (cmode_q ? ((erise_q & ext_rise) | (efall_q & ext_fall)) : 1'b1);

  tmr_prescale #(.W(CNT_W)) u_presc (
    .clk(clk), .rst(rst), .step(cnt_event), .limit(plim_q), .clear(any_rst),
    .load(wr_pcnt), .load_val(reg_wdata), .count(pc), .tick(tick)
  );

  // compare channels
  for (genvar i = 0; i < NUM_MATCH; i++) begin : g_match
    assign hit[i]    = tick & (tc_q == mr_q[i]);
    assign m_irq[i]  = mctl_q[3*i];
    assign m_rst[i]  = mctl_q[3*i+1];
    assign m_stop[i] = mctl_q[3*i+2];
    tmr_match_pin u_pin (
      .clk(clk), .rst(rst), .hit(hit[i]),
      .act(out_act_e'(octl_q[2*i +: 2])), .pin(match_out[i])
    );
  end

  assign any_rst  = |(hit & m_rst);
  assign any_stop = |(hit & m_stop);

  // main counter and run enable; a software write to the count wins
  always_ff @(posedge clk) begin
    if (rst)                       tc_q <= '0;
    else if (wr_count)             tc_q <= reg_wdata;
    else if (any_rst)              tc_q <= '0;
    else if (tick && !any_stop)    tc_q <= tc_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)           en_q <= 1'b0;
    else if (any_stop) en_q <= 1'b0;
    else if (wr_ctrl)  en_q <= reg_wdata[0];
  end

  // snapshot channels
  for (genvar i = 0; i < NUM_CAP; i++) begin : g_cap
    tmr_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .din(cap_in[i]), .rise(c_rise[i]), .fall(c_fall[i])
    );
    assign c_evt[i] = (cctl_q[3*i] & c_rise[i]) | (cctl_q[3*i+1] & c_fall[i]);
    assign c_irq[i] = cctl_q[3*i+2];
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_CAP; i++) begin
      if (rst) cr_q[i] <= '0;
      else if (c_evt[i]) cr_q[i] <= tc_q;
    end
  end

  // sticky status, write-one-to-clear, new events win
  assign st_clr = wr_status ? reg_wdata[ST_W-1:0] : '0;
  assign st_nxt = (st_q & ~st_clr) | {c_evt & c_irq, hit & m_irq};

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= '0;
      irq  <= 1'b0;
    end else begin
      st_q <= st_nxt;
      irq  <= |st_nxt;
    end
  end

  // read path
  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      ADDR_W'(A_CTRL):   rd_mux = CNT_W'({efall_q, erise_q, cmode_q, en_q});
      ADDR_W'(A_COUNT):  rd_mux = tc_q;
      ADDR_W'(A_PRESC):  rd_mux = plim_q;
      ADDR_W'(A_PCNT):   rd_mux = pc;
      ADDR_W'(A_STATUS): rd_mux = CNT_W'(st_q);
      ADDR_W'(A_MCTL):   rd_mux = CNT_W'(mctl_q);
      ADDR_W'(A_CCTL):   rd_mux = CNT_W'(cctl_q);
      ADDR_W'(A_OCTL):   rd_mux = CNT_W'(octl_q);
      default:           rd_mux = '0;
    endcase
    for (int i = 0; i < NUM_MATCH; i++)
      if (reg_addr == ADDR_W'(A_MATCH0 + i)) rd_mux = mr_q[i];
    for (int i = 0; i < NUM_CAP; i++)
      if (reg_addr == ADDR_W'(CAP_BASE + i)) rd_mux = cr_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/tmr_match_capture_chk.sv
module tmr_match_capture_chk
  import tmr_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int NUM_MATCH = 4,
  parameter int NUM_CAP   = 4,
  parameter int ADDR_W    = 5
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         reg_wr,
  input logic [ADDR_W-1:0]            reg_addr,
  input logic                         en,
  input logic [CNT_W-1:0]             count,
  input logic [NUM_MATCH+NUM_CAP-1:0] status,
  input logic                         irq,
  input logic [NUM_MATCH-1:0]         match_out,
  input logic [NUM_MATCH-1:0]         hit,
  input logic [3*NUM_MATCH-1:0]       mctl
);
  logic wr_count;
  logic [NUM_MATCH-1:0] rmask, smask, imask;

  assign wr_count = reg_wr && (reg_addr == ADDR_W'(A_COUNT));

  always_comb begin
    for (int i = 0; i < NUM_MATCH; i++) begin
      imask[i] = mctl[3*i];
      rmask[i] = mctl[3*i+1];
      smask[i] = mctl[3*i+2];
    end
  end

  a_r1_reset_values: assert property (@(posedge clk)
    rst |=> (count == '0 && !irq && match_out == '0 && !en));

  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    (!en && !wr_count) |=> $stable(count));

  a_r4_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
    ((|(hit & rmask)) && !wr_count) |=> (count == '0));

  a_r5_stop_clears_enable: assert property (@(posedge clk) disable iff (rst)
    (|(hit & smask)) |=> !en);

  a_r6_status_sets: assert property (@(posedge clk) disable iff (rst)
    (|(hit & imask)) |=>
      ((status[NUM_MATCH-1:0] & $past(hit & imask)) == $past(hit & imask)));

  a_r6_irq_tracks_status: assert property (@(posedge clk) disable iff (rst)
    ((|status) == irq));

  a_r7_pins_move_on_hit: assert property (@(posedge clk) disable iff (rst)
    (hit == '0) |=> $stable(match_out));
endmodule

bind tmr_match_capture tmr_match_capture_chk #(
  .CNT_W(CNT_W), .NUM_MATCH(NUM_MATCH), .NUM_CAP(NUM_CAP), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .en(en_q),
  .count(tc_q), .status(st_q), .irq(irq), .match_out(match_out),
  .hit(hit), .mctl(mctl_q)
);

// File: tb/tmr_match_capture_test.sv
`timescale 1ns/1ps
module tmr_match_capture_test;
  localparam int W = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] reg_rdata;
  logic        ext_clk = 1'b0;
  logic [3:0]  cap_in = '0;
  logic [3:0]  match_out;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  tmr_match_capture uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_clk(ext_clk),
    .cap_in(cap_in), .match_out(match_out), .irq(irq)
  );

  typedef struct packed {
    logic [31:0] pre;
    logic [31:0] mtch;
    logic [2:0]  mc;
    logic [15:0] k;
    logic [31:0] cexp;
    logic        sexp;
  } vec_t;

  // prescale, compare value, action bits {stop,reset,irq}, events, expected count, expected status bit 0
  localparam vec_t VECS [10] = '{
    '{32'd0, 32'd100, 3'b000, 16'd10, 32'd10, 1'b0},
    '{32'd2, 32'd100, 3'b000, 16'd10, 32'd3,  1'b0},
    '{32'd0, 32'd3,   3'b010, 16'd10, 32'd2,  1'b0},
    '{32'd1, 32'd2,   3'b010, 16'd13, 32'd0,  1'b0},
    '{32'd0, 32'd5,   3'b100, 16'd20, 32'd5,  1'b0},
    '{32'd3, 32'd2,   3'b100, 16'd40, 32'd2,  1'b0},
    '{32'd4, 32'd7,   3'b010, 16'd50, 32'd2,  1'b0},
    '{32'd0, 32'd0,   3'b010, 16'd7,  32'd0,  1'b0},
    '{32'd0, 32'd4,   3'b001, 16'd10, 32'd10, 1'b1},
    '{32'd1, 32'd6,   3'b011, 16'd10, 32'd5,  1'b0}
  };

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [W-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 5'(a); reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [W-1:0] d);
    @(negedge clk);
    reg_addr = 5'(a);
    @(posedge clk); #1;
    d = reg_rdata;
  endtask

  task automatic prep(input logic [W-1:0] pre);
    wr(0, 0); wr(1, 0); wr(3, 0); wr(2, pre); wr(4, 32'hFF);
  endtask

  task automatic pulse_ext(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) ext_clk = 1'b1;
      repeat (4) @(posedge clk);
      @(negedge clk) ext_clk = 1'b0;
      repeat (4) @(posedge clk);
    end
    repeat (4) @(posedge clk);
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    logic [W-1:0] d, d2;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    chk("R1 irq", W'(irq), 0);
    chk("R1 match_out", W'(match_out), 0);
    rd(0, d); chk("R1 ctrl", d, 0);
    rd(1, d); chk("R1 count", d, 0);
    rd(4, d); chk("R1 status", d, 0);

    // R9 register round trip
    wr(11, 32'hDEADBEEF); rd(11, d); chk("R9 match3 readback", d, 32'hDEADBEEF);
    wr(11, 0);

    // vector walk: R2 plain counting, R4 wrap, R5 stop, R6 status
    for (int v = 0; v < 10; v++) begin
      string tag;
      tag = VECS[v].mc[1] ? "R4" : (VECS[v].mc[2] ? "R5" : "R2");
      prep(VECS[v].pre);
      wr(8, VECS[v].mtch);
      wr(5, W'(VECS[v].mc));
      wr(0, 1);
      repeat (int'(VECS[v].k) - 1) @(posedge clk);
      wr(0, 0);
      rd(1, d); chk(tag, d, VECS[v].cexp);
      rd(4, d); chk("R6 vector status", W'(d[0]), W'(VECS[v].sexp));
    end

    // R2 hold while disabled
    rd(1, d); repeat (10) @(posedge clk); rd(1, d2);
    chk("R2 hold", d2, d);

    // R6 irq timing and write-one-to-clear
    prep(0); wr(8, 2); wr(5, 1); wr(0, 1);
    repeat (2) @(posedge clk); #1;
    chk("R6 irq before hit", W'(irq), 0);
    @(posedge clk); #1;
    chk("R6 irq at hit", W'(irq), 1);
    wr(0, 0);
    rd(4, d); chk("R6 status bit0", d, 1);
    wr(4, 2); chk("R6 wrong bit keeps irq", W'(irq), 1);
    wr(4, 1); chk("R6 clear drops irq", W'(irq), 0);

    // R5 stop clears the enable bit without software help
    prep(0); wr(8, 2); wr(5, 3'b100); wr(0, 1);
    repeat (10) @(posedge clk);
    rd(0, d); chk("R5 enable cleared", W'(d[0]), 0);
    rd(1, d); chk("R5 count held", d, 2);

    // R7 output actions
    prep(0); wr(8, 3); wr(5, 3'b010); wr(9, 1); wr(10, 2); wr(11, 0);
    wr(7, 32'h2C);
    wr(0, 1); repeat (2) @(posedge clk); wr(0, 0);
    chk("R7 toggle and high", W'(match_out), 32'h6);
    wr(10, 0); wr(7, 32'h1C);
    wr(0, 1); repeat (1) @(posedge clk); wr(0, 0);
    chk("R7 low and keep", W'(match_out), 32'h2);

    // R8 snapshots
    wr(0, 0); wr(7, 0); wr(4, 32'hFF);
    wr(6, 32'h15); wr(1, 32'h1234);
    @(negedge clk) cap_in = 4'b0011;
    repeat (5) @(posedge clk);
    rd(12, d); chk("R8 rising snapshot", d, 32'h1234);
    rd(13, d); chk("R8 rising ignored on fall-only", d, 0);
    rd(4, d);  chk("R8 snapshot irq", d, 32'h10);
    wr(1, 32'h55);
    @(negedge clk) cap_in = 4'b0000;
    repeat (5) @(posedge clk);
    rd(13, d); chk("R8 falling snapshot", d, 32'h55);
    rd(12, d); chk("R8 falling ignored on rise-only", d, 32'h1234);
    rd(4, d);  chk("R8 no irq when disabled", d, 32'h10);

    // R3 external counting
    wr(5, 0); prep(0); wr(0, 32'h7);
    pulse_ext(5);
    rd(1, d); chk("R3 rising edges", d, 5);
    prep(1); wr(0, 32'hF);
    pulse_ext(5);
    rd(1, d); chk("R3 both edges with prescale", d, 5);
    wr(0, 0);

    finish_up();
  end
endmodule